// File: doc/BRIEF.md
# E1 CRC-4 E-Bit Source Selector

This block supplies the two E bits of the E1 CRC-4 multiframe to the transmit framer. The E bits go in bit 1 of the non-alignment timeslot 0. The bit in frame 13 answers for received submultiframe 1, and the bit in frame 15 answers for received submultiframe 2. The framer tells the block where it is in the multiframe with a frame-start strobe and a frame index. The block returns the E-bit value together with a one-cycle valid strobe, and the framer writes that value into the outgoing timeslot.

A 2-bit configuration input picks where the E bits come from. The first choice reports received CRC-4 errors: a bit is sent as 0 when the matching submultiframe failed its check. The other choices are a constant 0, a constant 1, or a serial data-link bit fetched from an HDLC controller through a request and valid handshake. The configuration can be changed at any time, but it is only sampled when multiframe frame 0 begins, so no multiframe ever mixes two sources.

Top module: `e1_ebit_sel`

## Requirements
- R1: After reset, `ebit_vld` and `hdlc_req` are 0. Until the first frame-0 start, the active source is internal error reporting, whatever `src_sel` holds.
- R2: `ebit_vld` is high for exactly the one cycle that follows a `frm_start` cycle whose `frm_idx` is 13 (slot 1) or 15 (slot 2). It is low at every other time, and `ebit_val` is valid in that same cycle.
- R3: With code 00 (internal), a slot sends 0 if its CRC error strobe has been seen since the previous slot of the same number. The window includes the slot's own `frm_start` cycle. Otherwise the slot sends 1. `crc_err[0]` belongs to slot 1 and `crc_err[1]` belongs to slot 2.
- R4: A pending error indication is cleared when its slot goes out, whatever the source. A slot with no new strobe after it then sends 1.
- R5: With code 01, every E bit sent is 0.
- R6: With code 10, every E bit sent is 1.
- R7: With code 11, `hdlc_req` pulses high for one cycle in the cycle after a `frm_start` of frame 12 or frame 14. With any other code it never rises.
- R8: With code 11, a slot sends `hdlc_bit` from the first cycle in which `hdlc_bit_vld` is high, counted from the `hdlc_req` cycle up to and including the slot's `frm_start` cycle. Valid pulses outside that window, and any later pulses inside it, are ignored.
- R9: With code 11, a slot whose window saw no `hdlc_bit_vld` sends 1.
- R10: `src_sel` is sampled only in a `frm_start` cycle with `frm_idx` equal to 0. A change made at any other time does not affect the E bits until that point.
- R11: An error strobe for one submultiframe has no effect on the other slot's E bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | E-bit source code: 00 internal, 01 zero, 10 one, 11 HDLC |
| frm_start | input | 1 | One-cycle strobe at the start of each frame |
| frm_idx | input | 4 | Frame number 0..15 within the multiframe, valid with `frm_start` |
| crc_err | input | 2 | Received CRC-4 error strobes; bit 0 for submultiframe 1, bit 1 for submultiframe 2 |
| hdlc_req | output | 1 | One-cycle request for the next data-link bit |
| hdlc_bit_vld | input | 1 | The HDLC controller presents a bit |
| hdlc_bit | input | 1 | Data-link bit value |
| ebit_vld | output | 1 | E-bit value valid for insertion |
| ebit_val | output | 1 | E-bit value |

## Verification
Each piece of internal state shows up at the ports at the next E-bit slot, at most 16 frames later. A stuck or uncleared pending error shows as a 0 that should have been a 1 in the following multiframe. A lost or stale captured HDLC bit shows as the wrong level in the slot that ends its window. A source register loaded at the wrong time shows as a multiframe in which the two slots disagree with the configuration sampled at frame 0. The sweep changes the source in the middle of every multiframe, so the slots of each multiframe tell apart the configuration that is active and the one that is merely pending.

// File: rtl/e1_ebit_pkg.sv
package e1_ebit_pkg;
   typedef enum logic [1:0] {
      SRC_INTERNAL = 2'b00,
      SRC_ZERO     = 2'b01,
      SRC_ONE      = 2'b10,
      SRC_HDLC     = 2'b11
   } ebit_src_e;
endpackage

// File: rtl/e1_ebit_slot_decode.sv
module e1_ebit_slot_decode #(
   parameter int MF_LEN      = 16,
   parameter int N_SLOT      = 2,
   parameter int SLOT_FRAME0 = 13,
   parameter int SLOT_STEP   = 2,
   parameter int REQ_LEAD    = 1,
   localparam int FIDX_W     = $clog2(MF_LEN)
) (
   input  logic              frm_start,
   input  logic [FIDX_W-1:0] frm_idx,
   output logic              mf_start,
   output logic [N_SLOT-1:0] slot_hit,
   output logic [N_SLOT-1:0] req_hit
);
   if (SLOT_FRAME0 + (N_SLOT - 1) * SLOT_STEP >= MF_LEN) begin : g_bad_slot
      $error("last E-bit slot lies outside the multiframe");
   end
   if (REQ_LEAD < 1 || REQ_LEAD >= SLOT_STEP || REQ_LEAD > SLOT_FRAME0) begin : g_bad_lead
      $error("request lead must be at least one frame and shorter than the slot spacing");
   end

   assign mf_start = frm_start && (frm_idx == '0);

   for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
      localparam int SF = SLOT_FRAME0 + k * SLOT_STEP;
      localparam int RF = SF - REQ_LEAD;
      assign slot_hit[k] = frm_start && (frm_idx == FIDX_W'(SF));
      assign req_hit[k]  = frm_start && (frm_idx == FIDX_W'(RF));
   end
endmodule

// File: rtl/e1_ebit_err_latch.sv
module e1_ebit_err_latch #(
   parameter int N_SLOT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SLOT-1:0] err_in,
   input  logic [N_SLOT-1:0] slot_hit,
   output logic [N_SLOT-1:0] err_now
);
   logic [N_SLOT-1:0] pend_q;

   for (genvar k = 0; k < N_SLOT; k++) begin : g_pend
      always_ff @(posedge clk) begin
         if (!rst_n)           pend_q[k] <= 1'b0;
         else if (slot_hit[k]) pend_q[k] <= 1'b0;
         else if (err_in[k])   pend_q[k] <= 1'b1;
      end
      assign err_now[k] = pend_q[k] | err_in[k];

      // R4: an indication never survives its own slot
      assert_err_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
         slot_hit[k] |=> !pend_q[k]);
      // R3: a strobe away from the slot stays pending
      assert_err_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (err_in[k] && !slot_hit[k]) |=> pend_q[k]);
   end
endmodule

// File: rtl/e1_ebit_hdlc_fetch.sv
module e1_ebit_hdlc_fetch #(
   parameter int   N_SLOT    = 2,
   parameter logic IDLE_FILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [N_SLOT-1:0] req_hit,
   input  logic [N_SLOT-1:0] slot_hit,
   input  logic              bit_vld,
   input  logic              bit_in,
   output logic              req,
   output logic              bit_now
);
   logic waiting_q, have_q, bit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req       <= 1'b0;
         waiting_q <= 1'b0;
         have_q    <= 1'b0;
         bit_q     <= 1'b0;
      end else begin
         req <= enable && (|req_hit);
         if (|slot_hit) begin
            waiting_q <= 1'b0;
            have_q    <= 1'b0;
         end else if (enable && (|req_hit)) begin
            waiting_q <= 1'b1;
            have_q    <= 1'b0;
         end else if (waiting_q && !have_q && bit_vld) begin
            have_q <= 1'b1;
            bit_q  <= bit_in;
         end
      end
   end

   always_comb begin
      if (have_q)                    bit_now = bit_q;
      else if (waiting_q && bit_vld) bit_now = bit_in;
      else                           bit_now = IDLE_FILL;
   end

   // R7: request is a single-cycle pulse
   assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);
   // R8: a captured bit is held until the slot
   assert_bit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && !(|slot_hit)) |=> (have_q && $stable(bit_q)));
endmodule

// File: rtl/e1_ebit_sel.sv
module e1_ebit_sel
   import e1_ebit_pkg::*;
#(
   parameter int   MF_LEN      = 16,
   parameter int   SLOT_FRAME0 = 13,
   parameter int   SLOT_STEP   = 2,
   parameter int   REQ_LEAD    = 1,
   parameter logic IDLE_FILL   = 1'b1,
   localparam int  N_SLOT      = 2,
   localparam int  FIDX_W      = $clog2(MF_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        src_sel,
   input  logic              frm_start,
   input  logic [FIDX_W-1:0] frm_idx,
   input  logic [N_SLOT-1:0] crc_err,
   output logic              hdlc_req,
   input  logic              hdlc_bit_vld,
   input  logic              hdlc_bit,
   output logic              ebit_vld,
   output logic              ebit_val
);
   logic              mf_start;
   logic [N_SLOT-1:0] slot_hit, req_hit, err_now;
   logic              hdlc_now, err_sel, val_d;
   ebit_src_e         active_q;

   e1_ebit_slot_decode #(
      .MF_LEN(MF_LEN), .N_SLOT(N_SLOT), .SLOT_FRAME0(SLOT_FRAME0),
      .SLOT_STEP(SLOT_STEP), .REQ_LEAD(REQ_LEAD)
   ) u_decode (
      .frm_start(frm_start), .frm_idx(frm_idx),
      .mf_start(mf_start), .slot_hit(slot_hit), .req_hit(req_hit)
   );

   e1_ebit_err_latch #(.N_SLOT(N_SLOT)) u_err (
      .clk(clk), .rst_n(rst_n), .err_in(crc_err),
      .slot_hit(slot_hit), .err_now(err_now)
   );

   e1_ebit_hdlc_fetch #(.N_SLOT(N_SLOT), .IDLE_FILL(IDLE_FILL)) u_hdlc (
      .clk(clk), .rst_n(rst_n), .enable(active_q == SRC_HDLC),
      .req_hit(req_hit), .slot_hit(slot_hit),
      .bit_vld(hdlc_bit_vld), .bit_in(hdlc_bit),
      .req(hdlc_req), .bit_now(hdlc_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        active_q <= SRC_INTERNAL;
      else if (mf_start) active_q <= ebit_src_e'(src_sel);
   end

   assign err_sel = |(slot_hit & err_now);

   always_comb begin
      unique case (active_q)
         SRC_INTERNAL: val_d = !err_sel;
         SRC_ZERO:     val_d = 1'b0;
         SRC_ONE:      val_d = 1'b1;
         SRC_HDLC:     val_d = hdlc_now;
         default:      val_d = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ebit_vld <= 1'b0;
         ebit_val <= 1'b1;
      end else begin
         ebit_vld <= |slot_hit;
         if (|slot_hit) ebit_val <= val_d;
      end
   end

   // R2: valid only right after a frame start
   assert_vld_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ebit_vld |-> $past(frm_start));
   assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ebit_vld |=> !ebit_vld);
   // R5 / R6: forced sources
   assert_force_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ebit_vld && active_q == SRC_ZERO) |-> !ebit_val);
   assert_force_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ebit_vld && active_q == SRC_ONE) |-> ebit_val);
   // R7: no request outside the data-link source
   assert_req_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hdlc_req |-> (active_q == SRC_HDLC));
   // R10: source changes only at the multiframe boundary
   assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_start |=> $stable(active_q));
endmodule

// File: tb/e1_ebit_sel_bench.sv
`timescale 1ns/1ps
module e1_ebit_sel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_sel = 2'b00;
   logic       frm_start = 1'b0;
   logic [3:0] frm_idx = 4'd0;
   logic [1:0] crc_err = 2'b00;
   logic       hdlc_bit_vld = 1'b0;
   logic       hdlc_bit = 1'b0;
   logic       hdlc_req, ebit_vld, ebit_val;

   int n_chk = 0, n_fail = 0;
   logic [1:0] m_act = 2'b00;
   logic [1:0] m_pend = 2'b00;
   logic [1:0] m_got = 2'b00;
   logic [1:0] m_bit = 2'b00;
   bit done = 0;

   always #2.5 clk = ~clk;

   e1_ebit_sel u_e1_ebit_sel (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .frm_start(frm_start),
      .frm_idx(frm_idx), .crc_err(crc_err), .hdlc_req(hdlc_req),
      .hdlc_bit_vld(hdlc_bit_vld), .hdlc_bit(hdlc_bit),
      .ebit_vld(ebit_vld), .ebit_val(ebit_val)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic logic [1:0] cfg_mode(input int i);
      logic [5:0] v = 6'(i);
      return v[5:4] ^ v[3:2];
   endfunction

   // one multiframe; frames lo..15; e = error pattern, h = HDLC response pattern
   task automatic run_mf(input int lo, input logic [1:0] nxt, input logic [1:0] e,
                         input logic [1:0] h);
      for (int f = lo; f < 16; f++) begin
         int  k;
         logic exp_v;
         k = (f == 13) ? 0 : ((f == 15) ? 1 : -1);
         @(negedge clk);
         frm_start = 1'b1;
         frm_idx   = 4'(f);
         crc_err   = 2'b00;
         if (f == 0) m_act = src_sel;
         if (f == 5 && e != 2'b11) crc_err[0] = e[0];
         if (f == 13 && e == 2'b11) crc_err[0] = 1'b1;   // strobe in the slot cycle
         if (f == 10) crc_err[1] = e[1];
         if (f == 8) src_sel = nxt;
         m_pend = m_pend | crc_err;
         exp_v = 1'b1;
         if (k >= 0) begin
            case (m_act)
               2'b00: exp_v = !m_pend[k];
               2'b01: exp_v = 1'b0;
               2'b10: exp_v = 1'b1;
               default: exp_v = m_got[k] ? m_bit[k] : 1'b1;
            endcase
            m_pend[k] = 1'b0;
            m_got[k]  = 1'b0;
         end
         @(negedge clk);
         frm_start = 1'b0;
         crc_err   = 2'b00;
         check("R2 vld", ebit_vld, k >= 0);
         if (k >= 0) begin
            case (m_act)
               2'b00: check(f == 13 ? "R3/R4/R11 internal slot1" : "R3/R4/R11 internal slot2", ebit_val, exp_v);
               2'b01: check("R5 forced zero", ebit_val, exp_v);
               2'b10: check("R6 forced one", ebit_val, exp_v);
               default: check(h[0] ? "R8 hdlc bit" : "R9 hdlc fill", ebit_val, exp_v);
            endcase
         end
         check("R7 hdlc_req", hdlc_req, (m_act == 2'b11) && (f == 12 || f == 14));
         for (int c = 0; c < 3; c++) begin
            hdlc_bit_vld = 1'b0;
            if (f == 3 && c == 0) begin            // stray pulse outside any window
               hdlc_bit_vld = 1'b1;
               hdlc_bit     = 1'b0;
            end
            if ((f == 12 || f == 14) && h[0] && m_act == 2'b11) begin
               int s = (f == 12) ? 0 : 1;
               logic b = (s == 0) ? h[1] : !h[1];
               if (c == 0) begin
                  hdlc_bit_vld = 1'b1; hdlc_bit = b;
                  m_got[s] = 1'b1; m_bit[s] = b;
               end else if (c == 1) begin      // later pulse, must be ignored
                  hdlc_bit_vld = 1'b1; hdlc_bit = !b;
               end
            end
            @(negedge clk);
            check("R2 vld idle", ebit_vld, 1'b0);
         end
         hdlc_bit_vld = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset vld", ebit_vld, 1'b0);
      check("R1 reset req", hdlc_req, 1'b0);
      rst_n   = 1'b1;
      src_sel = 2'b01;                 // must not apply before a frame 0
      // R1: partial multiframe, active source still internal, no errors -> 1
      run_mf(12, cfg_mode(0), 2'b00, 2'b00);
      // R10: sel changes mid-multiframe in every round of the sweep
      for (int i = 0; i < 64; i++) begin
         logic [5:0] v = 6'(i);
         run_mf(0, cfg_mode(i + 1), v[1:0], v[3:2]);
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule